// File: doc/BRIEF.md
# Speculative Load Address Table

This block keeps a record of loads that a compiler has moved above stores that might write the same bytes. When such a load issues, the table records which register it wrote, the byte address it read, and how many bytes it read. Every later store is compared against all of the recorded loads at once. Any recorded load whose bytes overlap the store is dropped, because its value may now be stale.

Before the speculatively loaded value is used, a check names the register. The table answers pass if a live record for that register still exists, and fail otherwise. A fail sends the core to recovery code. On a pass, the check may also release the record.

The table is fully associative and holds one record per register. Free slots are filled before any live record is evicted. When every slot is live, a round-robin pointer chooses the slot to replace.

Top module: `spec_addr_table`

## Requirements
- R1: After reset no record is live: a check of any register answers fail, and `chkDone` stays low until a check is presented.
- R2: A load with `ldValid` high creates a record for `ldReg`. A check (`chkValid`) of that register answers on the next clock edge with `chkDone` high and `chkPass` high. `chkDone` is high exactly in the cycle after each cycle with `chkValid` high.
- R3: A check of a register with no live record answers `chkDone` high and `chkPass` low.
- R4: A store kills every record whose byte range overlaps the store's byte range. A range is [addr, addr + bytes). The size code sets the byte count: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. Ranges overlap when each range starts below the other's end.
- R5: A store whose range only touches or misses a record's range leaves that record live. A later check of that register passes.
- R6: A load to a register that already has a record overwrites that record. Only the new address and size are compared against later stores.
- R7: A new register's load takes the lowest-index free slot. When all 16 slots are live, it evicts the slot named by a victim pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each eviction. Slots are filled by index order, so the first eviction drops the register loaded first.
- R8: A passing check with `chkClear` high releases the record, so the next check of that register fails. With `chkClear` low the record stays live.
- R9: When a store and a check arrive in the same cycle, the store's kill applies first. A check of a record that this store overlaps answers fail.
- R10: A load in the same cycle as a store is not killed by that store. A check in the same cycle as a load sees the table as it was before that load.
- R11: The table never holds two live records for the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ldValid | input | 1 | Speculative load issues this cycle |
| ldReg | input | REG_W | Destination register of the load |
| ldAddr | input | ADDR_W | First byte address read by the load |
| ldSize | input | 2 | Load size code (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes) |
| stValid | input | 1 | Store issues this cycle |
| stAddr | input | ADDR_W | First byte address written by the store |
| stSize | input | 2 | Store size code, same encoding as the load size code |
| chkValid | input | 1 | Check of a register issues this cycle |
| chkReg | input | REG_W | Register being checked |
| chkClear | input | 1 | Release the record if the check passes |
| chkDone | output | 1 | A check answer is present (one cycle after `chkValid`) |
| chkPass | output | 1 | The checked record was live; meaningful while `chkDone` is high |

## Verification
The bench targets the following corner cases:

- **Partial overlaps and adjacent ranges.** It stores one byte just past a four-byte record and one byte at that record's last byte. A comparator that matched only start addresses, or that used `<=` at a range end, would miss the partial overlap or kill the adjacent record.
- **Eviction and replacement.** It fills all 16 slots, then loads a 17th register and a 18th. A design that evicted the wrong slot, or did not advance the victim pointer, would fail a different register's check. A design that reused a register's slot poorly would leave a stale second record, which a later store would not kill.
- **Same-cycle ordering.** It issues a store with an overlapping check, and a load with a store and a check of the same register. A design that ordered these wrongly would pass a check that should fail, or kill its own new record.

A seeded random stream over 24 registers and a narrow address window then hits all of these paths together.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int SAT_ENTRIES = 16;
  localparam int SAT_IDX_W   = $clog2(SAT_ENTRIES);
  localparam int SAT_SIZE_W  = 2;

  // control to datapath: write one slot's tags this cycle
  typedef struct packed {
    logic                 wrEn;
    logic [SAT_IDX_W-1:0] wrIdx;
  } sat_strobe_t;
endpackage

// File: rtl/sat_tags.sv
module sat_tags
  import sat_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  sat_strobe_t            strobe,
  input  logic [REG_W-1:0]       ldReg,
  input  logic [ADDR_W-1:0]      ldAddr,
  input  logic [SAT_SIZE_W-1:0]  ldSize,
  input  logic [ADDR_W-1:0]      stAddr,
  input  logic [SAT_SIZE_W-1:0]  stSize,
  input  logic [REG_W-1:0]       chkReg,
  output logic [SAT_ENTRIES-1:0] ldRegHit,
  output logic [SAT_ENTRIES-1:0] chkRegHit,
  output logic [SAT_ENTRIES-1:0] stOverlap
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] stLo;
  logic [EXT_W-1:0] stHi;

  // one extra bit keeps the end address exact at the top of memory
  assign stLo = {1'b0, stAddr};
  assign stHi = stLo + (EXT_W'(1) << stSize);

  for (genvar e = 0; e < SAT_ENTRIES; e++) begin : g_slot
    logic [REG_W-1:0]      tagReg;
    logic [ADDR_W-1:0]     tagAddr;
    logic [SAT_SIZE_W-1:0] tagSize;
    logic [EXT_W-1:0]      slotLo;
    logic [EXT_W-1:0]      slotHi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tagReg  <= '0;
        tagAddr <= '0;
        tagSize <= '0;
      end else if (strobe.wrEn && strobe.wrIdx == SAT_IDX_W'(e)) begin
        tagReg  <= ldReg;
        tagAddr <= ldAddr;
        tagSize <= ldSize;
      end
    end

    assign slotLo       = {1'b0, tagAddr};
    assign slotHi       = slotLo + (EXT_W'(1) << tagSize);
    assign ldRegHit[e]  = (tagReg == ldReg);
    assign chkRegHit[e] = (tagReg == chkReg);
    assign stOverlap[e] = (slotLo < stHi) && (stLo < slotHi);
  end
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ldValid,
  input  logic                   stValid,
  input  logic                   chkValid,
  input  logic                   chkClear,
  input  logic [SAT_ENTRIES-1:0] ldRegHit,
  input  logic [SAT_ENTRIES-1:0] chkRegHit,
  input  logic [SAT_ENTRIES-1:0] stOverlap,
  output sat_strobe_t            strobe,
  output logic                   chkDone,
  output logic                   chkPass
);
  logic [SAT_ENTRIES-1:0] valid;
  logic [SAT_ENTRIES-1:0] kill;
  logic [SAT_ENTRIES-1:0] sameReg;
  logic [SAT_ENTRIES-1:0] chkLive;
  logic [SAT_ENTRIES-1:0] clr;
  logic [SAT_ENTRIES-1:0] validNext;
  logic [SAT_IDX_W-1:0]   rrPtr;
  logic [SAT_IDX_W-1:0]   sameIdx;
  logic [SAT_IDX_W-1:0]   freeIdx;
  logic                   tableFull;
  logic                   evict;

  function automatic logic [SAT_IDX_W-1:0] stepPtr(input logic [SAT_IDX_W-1:0] p);
    if (p == SAT_IDX_W'(SAT_ENTRIES - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign kill      = stValid ? (valid & stOverlap) : '0;
  assign sameReg   = valid & ldRegHit;
  assign chkLive   = valid & chkRegHit & ~kill;
  assign clr       = (chkValid && chkClear) ? chkLive : '0;
  assign tableFull = &valid;
  assign evict     = ldValid && tableFull && !(|sameReg);

  always_comb begin
    sameIdx = '0;
    freeIdx = '0;
    for (int i = SAT_ENTRIES - 1; i >= 0; i--) begin
      if (sameReg[i]) sameIdx = SAT_IDX_W'(i);
      if (!valid[i])  freeIdx = SAT_IDX_W'(i);
    end
  end

  always_comb begin
    strobe.wrEn = ldValid;
    if (|sameReg)       strobe.wrIdx = sameIdx;
    else if (!tableFull) strobe.wrIdx = freeIdx;
    else                strobe.wrIdx = rrPtr;
  end

  always_comb begin
    validNext = valid & ~kill & ~clr;
    if (strobe.wrEn) validNext[strobe.wrIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= '0;
      rrPtr   <= '0;
      chkDone <= 1'b0;
      chkPass <= 1'b0;
    end else begin
      valid   <= validNext;
      chkDone <= chkValid;
      chkPass <= chkValid && (|chkLive);
      if (evict) rrPtr <= stepPtr(rrPtr);
    end
  end

  AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valid & chkRegHit)); // R11
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ldValid |=> valid[$past(strobe.wrIdx)]); // R2
  AST_STORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (stValid && chkValid && |(valid & chkRegHit & stOverlap)) |=> (chkDone && !chkPass)); // R9
  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && (&valid) && !(|(valid & ldRegHit))) |=> (rrPtr == stepPtr($past(rrPtr)))); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (chkValid && chkClear && !ldValid && |(valid & chkRegHit)) |=> !(|(valid & $past(valid & chkRegHit)))); // R8
endmodule

// File: rtl/spec_addr_table.sv
module spec_addr_table
  import sat_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  input  logic              chkClear,
  output logic              chkDone,
  output logic              chkPass
);
  sat_strobe_t            strobe;
  logic [SAT_ENTRIES-1:0] ldRegHit;
  logic [SAT_ENTRIES-1:0] chkRegHit;
  logic [SAT_ENTRIES-1:0] stOverlap;

  sat_tags #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_tags (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .ldReg(ldReg), .ldAddr(ldAddr), .ldSize(ldSize),
    .stAddr(stAddr), .stSize(stSize), .chkReg(chkReg),
    .ldRegHit(ldRegHit), .chkRegHit(chkRegHit), .stOverlap(stOverlap)
  );

  sat_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ldValid(ldValid), .stValid(stValid), .chkValid(chkValid), .chkClear(chkClear),
    .ldRegHit(ldRegHit), .chkRegHit(chkRegHit), .stOverlap(stOverlap),
    .strobe(strobe), .chkDone(chkDone), .chkPass(chkPass)
  );
endmodule

// File: tb/test_spec_addr_table.sv
module test_spec_addr_table;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 7;
  localparam int ADDR_W = 32;
  localparam int NSLOT  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ldValid = 1'b0;
  logic [REG_W-1:0]  ldReg = '0;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic [1:0]        ldSize = '0;
  logic              stValid = 1'b0;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [1:0]        stSize = '0;
  logic              chkValid = 1'b0;
  logic [REG_W-1:0]  chkReg = '0;
  logic              chkClear = 1'b0;
  logic              chkDone;
  logic              chkPass;

  int total = 0;
  int bad   = 0;

  bit          mV [NSLOT];
  int unsigned mR [NSLOT];
  longint      mA [NSLOT];
  int unsigned mS [NSLOT];
  int          mRr;

  spec_addr_table #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_spec_addr_table (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ovl(longint a1, int unsigned s1, longint a2, int unsigned s2);
    return (a1 < a2 + (64'd1 << s2)) && (a2 < a1 + (64'd1 << s1));
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < NSLOT; i++) mV[i] = 1'b0;
    mRr = 0;
  endfunction

  task automatic idle();
    ldValid = 0; stValid = 0; chkValid = 0; chkClear = 0;
  endtask

  // one clock: expected answer from the model's pre-edge state, then update model
  task automatic cyc(string tag);
    bit kill [NSLOT];
    bit expPass = 0;
    bit pc = chkValid;
    int same = -1, freeI = -1, idx;
    for (int i = 0; i < NSLOT; i++) begin
      kill[i] = stValid && mV[i] && ovl(mA[i], mS[i], longint'(stAddr), stSize);
      if (mV[i] && !kill[i] && mR[i] == chkReg) expPass = 1;
      if (mV[i] && mR[i] == ldReg && same < 0) same = i;
      if (!mV[i] && freeI < 0) freeI = i;
    end
    @(posedge clk);
    #1;
    if (ldValid) begin
      if (same >= 0) idx = same;
      else if (freeI >= 0) idx = freeI;
      else begin idx = mRr; mRr = (mRr + 1) % NSLOT; end
    end else idx = -1;
    for (int i = 0; i < NSLOT; i++) begin
      if (kill[i]) mV[i] = 0;
      if (pc && chkClear && mV[i] && mR[i] == chkReg) mV[i] = 0;
    end
    if (idx >= 0) begin
      mV[idx] = 1; mR[idx] = ldReg; mA[idx] = longint'(ldAddr); mS[idx] = ldSize;
    end
    if (pc) begin
      total++;
      if (chkDone !== 1'b1 || chkPass !== expPass) begin
        bad++;
        $display("FAIL %s reg=%0d done=%b pass=%b expected done=1 pass=%b", tag, chkReg, chkDone, chkPass, expPass);
      end
    end else if (chkDone !== 1'b0) begin
      total++; bad++;
      $display("FAIL %s idle cycle done=%b expected 0", tag, chkDone);
    end
  endtask

  task automatic doLoad(int r, int a, int s, string tag);
    idle(); ldValid = 1; ldReg = REG_W'(r); ldAddr = ADDR_W'(a); ldSize = 2'(s); cyc(tag);
  endtask
  task automatic doStore(int a, int s, string tag);
    idle(); stValid = 1; stAddr = ADDR_W'(a); stSize = 2'(s); cyc(tag);
  endtask
  task automatic doCheck(int r, bit c, string tag);
    idle(); chkValid = 1; chkReg = REG_W'(r); chkClear = c; cyc(tag);
  endtask

  task automatic resetDut();
    idle(); rst_n = 0; modelReset();
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
  endtask

  initial begin
    int seed = 32'h5A17;
    void'($urandom(seed));
    resetDut();
    total++;
    if (chkDone !== 1'b0) begin bad++; $display("FAIL R1 done=%b expected 0", chkDone); end
    doCheck(3, 0, "R1");
    doCheck(9, 0, "R3");
    // basic load and overlap rules
    doLoad(5, 100, 2, "R2");
    doCheck(5, 0, "R2");
    doStore(104, 0, "R5");
    doCheck(5, 0, "R5");
    doStore(96, 2, "R5");
    doCheck(5, 0, "R5");
    doStore(103, 0, "R4");
    doCheck(5, 0, "R4");
    doLoad(6, 200, 3, "R4");
    doStore(198, 2, "R4");
    doCheck(6, 0, "R4");
    // replacement of a register's record
    doLoad(7, 300, 3, "R6");
    doLoad(7, 400, 0, "R6");
    doStore(300, 3, "R6");
    doCheck(7, 0, "R6");
    doStore(400, 0, "R6");
    doCheck(7, 0, "R6");
    // clear on pass
    doLoad(8, 500, 1, "R8");
    doCheck(8, 0, "R8");
    doCheck(8, 1, "R8");
    doCheck(8, 0, "R8");
    // store and check together
    doLoad(10, 600, 2, "R9");
    idle(); stValid = 1; stAddr = 602; stSize = 0; chkValid = 1; chkReg = 10; cyc("R9");
    // load with store and check of same register together
    idle(); ldValid = 1; ldReg = 11; ldAddr = 700; ldSize = 2;
    stValid = 1; stAddr = 700; stSize = 2; chkValid = 1; chkReg = 11; cyc("R10");
    doCheck(11, 0, "R10");
    // fill and evict round robin
    resetDut();
    for (int r = 0; r < NSLOT; r++) doLoad(r, 1000 + 16*r, 0, "R7");
    doLoad(40, 5000, 0, "R7");
    doCheck(0, 0, "R7");
    doCheck(1, 0, "R7");
    doLoad(41, 5100, 0, "R7");
    doCheck(1, 0, "R7");
    doCheck(2, 0, "R7");
    doCheck(40, 0, "R11");
    // random mix
    resetDut();
    for (int n = 0; n < 4000; n++) begin
      idle();
      ldValid  = ($urandom % 2) == 0;
      ldReg    = REG_W'($urandom % 24);
      ldAddr   = ADDR_W'($urandom % 96);
      ldSize   = 2'($urandom % 4);
      stValid  = ($urandom % 10) < 3;
      stAddr   = ADDR_W'($urandom % 96);
      stSize   = 2'($urandom % 4);
      chkValid = ($urandom % 10) < 6;
      chkReg   = REG_W'($urandom % 24);
      chkClear = ($urandom % 2) == 0;
      cyc("R2 random");
    end
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule